// File: doc/BRIEF.md
# Dual-Window Security Configuration Register Bank

This block is a 32-bit memory-mapped register bank reached through two separate 4 KB address windows that share one set of state. The secure window owns the global security settings (a one-bit response mode and a two-bit callable-region setting), a bridge interrupt enable field, and two kinds of per-port masks for every peripheral protection controller: a non-secure mask and a secure-privilege mask. The non-secure window can see and change only the non-secure-privilege masks. Both windows return a fixed run of identification bytes at the top of the window.

A simple slave port supplies a window select, a word address inside the window, write data, an access size and separate read and write strobes. Every stored field is driven straight onto an output so the protection controllers around the block can use it without polling. Controllers come in three groups: AHB expansion, APB internal and APB expansion. Within a group, each controller has its own word in an aligned 16-byte block, and address bits [3:2] select the controller.

Top module: `secwin_regbank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every configuration field, bridge enable and mask output is zero from the next edge on, and `rdata` is zero.
- R2: In the secure window, a word write to 0x10 keeps only bit 0 as `resp_cfg`, and a word write to 0x14 keeps only bits [1:0] as `nsc_cfg`. Both values read back at the same offsets.
- R3: In the secure window, a word write to 0x48 keeps bits [31:16] as `brg_int_en`, and a read of 0x48 returns them in bits [31:16] with zeros below. A read of 0x40 returns zero.
- R4: Secure-window non-secure masks sit at 0x60 (AHB expansion), 0x70 (APB internal) and 0x80 (APB expansion). Controller i is at base + 4*i. Only the low MASK_W bits are stored, and they read back zero-extended. Controller i owns bits [i*MASK_W +: MASK_W] of the matching output.
- R5: Secure-window secure-privilege masks use the same layout at 0xA0, 0xB0 and 0xC0.
- R6: Non-secure-window non-secure-privilege masks use the same layout at 0xA0, 0xB0 and 0xC0. A write in the non-secure window never changes a secure-window field, and a secure-only offset reads zero in the non-secure window.
- R7: Offsets 0xFD0 to 0xFFC return one identification byte per word: 04,00,00,00,52,B8,0B,00,0D,F0,05,B1 in the secure window. The non-secure window returns the same run except that the byte at 0xFE0 is 0x53.
- R8: Size code 0 is one byte, 1 is two bytes and 2 is a word (code 3 reads as a word). A byte read returns bits [8*a +: 8] of the addressed word, where a is address bits [1:0]. A two-byte read returns bits [8*a +: 16] of the word, filled with zeros above bit 31. Both are zero-extended.
- R9: A write with a size code other than 2, or with address bits [1:0] not zero, changes no state.
- R10: Offsets 0x50 and 0x90, the clear offsets 0x24/0x34/0x44, the ID words, undecoded offsets and APB internal controllers 2 and 3 read zero or their fixed value, and writes to them change no state.
- R11: Read data is registered. It appears in the cycle after `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_ns | input | 1 | Window select: 0 secure, 1 non-secure |
| addr | input | 12 | Byte address inside the window |
| wdata | input | 32 | Write data |
| size | input | 2 | Access size code (0 byte, 1 half, 2 word) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| resp_cfg | output | 1 | Secure response mode |
| nsc_cfg | output | 2 | Callable-region setting |
| brg_int_en | output | 16 | Bridge interrupt enable field |
| ahbx_nonsec | output | NUM_AHBX*MASK_W | AHB expansion non-secure masks |
| apbi_nonsec | output | NUM_APBI*MASK_W | APB internal non-secure masks |
| apbx_nonsec | output | NUM_APBX*MASK_W | APB expansion non-secure masks |
| ahbx_secpriv | output | NUM_AHBX*MASK_W | AHB expansion secure-privilege masks |
| apbi_secpriv | output | NUM_APBI*MASK_W | APB internal secure-privilege masks |
| apbx_secpriv | output | NUM_APBX*MASK_W | APB expansion secure-privilege masks |
| ahbx_nspriv | output | NUM_AHBX*MASK_W | AHB expansion non-secure-privilege masks |
| apbi_nspriv | output | NUM_APBI*MASK_W | APB internal non-secure-privilege masks |
| apbx_nspriv | output | NUM_APBX*MASK_W | APB expansion non-secure-privilege masks |

## Verification
The assertions assume that `win_ns`, `addr`, `wdata` and `size` are known whenever a strobe is high, and that `rst_n` is driven low from time zero. The stimulus drives every input at the falling edge and holds it for one full cycle. It never raises `rd_en` and `wr_en` together, and it applies reset before any access, so the one-cycle stability and write-capture properties see a single clean access per cycle.

// File: rtl/secwin_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the dual-window register bank.
// Assumes word offsets are taken from address bits [11:2].
package secwin_pkg;

    // Which mask family a decoded access targets
    typedef enum logic [1:0] {
        KIND_NS  = 2'd0,
        KIND_SP  = 2'd1,
        KIND_NSP = 2'd2
    } mask_kind_e;

    // Which controller group a decoded access targets
    typedef enum logic [1:0] {
        GRP_AHBX = 2'd0,
        GRP_APBI = 2'd1,
        GRP_APBX = 2'd2,
        GRP_NONE = 2'd3
    } grp_e;

    typedef struct packed {
        logic       hit;
        mask_kind_e kind;
        grp_e       grp;
        logic [1:0] idx;
    } mask_sel_t;

    typedef struct packed {
        logic       resp;
        logic       call;
        logic       brgen;
        logic       id;
        logic [3:0] id_n;
        mask_sel_t  m;
    } dec_t;

    // Word offsets (byte offset >> 2)
    localparam logic [9:0] WOFS_RESP  = 10'h004;
    localparam logic [9:0] WOFS_CALL  = 10'h005;
    localparam logic [9:0] WOFS_BRGEN = 10'h012;

    localparam int unsigned SZ_WORD = 2;

    // Identification byte n (0..11) for the selected window
    function automatic logic [7:0] id_byte(input logic [3:0] n, input logic ns);
        logic [7:0] b;
        case (n)
            4'd0:    b = 8'h04;
            4'd4:    b = ns ? 8'h53 : 8'h52;
            4'd5:    b = 8'hB8;
            4'd6:    b = 8'h0B;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/secwin_decode.sv
`timescale 1ns/1ps
// Address decoder: maps a window select and word address onto one target.
// Assumes group counts are at most 4 (index comes from two address bits).
module secwin_decode
    import secwin_pkg::*;
#(
    parameter int NUM_AHBX = 4,
    parameter int NUM_APBI = 2,
    parameter int NUM_APBX = 4
) (
    input  logic       win_ns,
    input  logic [9:0] waddr,
    output dec_t       dec
);

    logic [3:0] nib;
    logic       low_page;

    assign nib      = waddr[5:2];
    assign low_page = (waddr[9:6] == 4'd0);

    // Classify the word address into exactly one register target
    always_comb begin
        dec        = '0;
        dec.m.grp  = GRP_NONE;
        dec.m.kind = KIND_NS;
        dec.m.idx  = waddr[1:0];
        if (!win_ns) begin
            dec.resp  = (waddr == WOFS_RESP);
            dec.call  = (waddr == WOFS_CALL);
            dec.brgen = (waddr == WOFS_BRGEN);
        end
        if (waddr[9:4] == 6'h3F && waddr[3:2] != 2'b00) begin
            dec.id   = 1'b1;
            dec.id_n = waddr[3:0] - 4'd4;
        end
        if (low_page) begin
            case (nib)
                4'h6: if (!win_ns) begin dec.m.grp = GRP_AHBX; dec.m.kind = KIND_NS; end
                4'h7: if (!win_ns) begin dec.m.grp = GRP_APBI; dec.m.kind = KIND_NS; end
                4'h8: if (!win_ns) begin dec.m.grp = GRP_APBX; dec.m.kind = KIND_NS; end
                4'hA: begin dec.m.grp = GRP_AHBX; dec.m.kind = win_ns ? KIND_NSP : KIND_SP; end
                4'hB: begin dec.m.grp = GRP_APBI; dec.m.kind = win_ns ? KIND_NSP : KIND_SP; end
                4'hC: begin dec.m.grp = GRP_APBX; dec.m.kind = win_ns ? KIND_NSP : KIND_SP; end
                default: dec.m.grp = GRP_NONE;
            endcase
        end
        case (dec.m.grp)
            GRP_AHBX: dec.m.hit = int'(waddr[1:0]) < NUM_AHBX;
            GRP_APBI: dec.m.hit = int'(waddr[1:0]) < NUM_APBI;
            GRP_APBX: dec.m.hit = int'(waddr[1:0]) < NUM_APBX;
            default:  dec.m.hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/secwin_mask_bank.sv
`timescale 1ns/1ps
// One group of per-controller masks of a single kind, with indexed readback.
// Assumes COUNT <= 4 and that the write enable is already qualified.
module secwin_mask_bank #(
    parameter int COUNT = 4,
    parameter int W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [1:0]         idx,
    input  logic [W-1:0]       wdata,
    output logic [COUNT*W-1:0] q,
    output logic [W-1:0]       rd_q
);

    for (genvar i = 0; i < COUNT; i++) begin : g_ent
        // Store the mask of controller i
        always_ff @(posedge clk) begin
            if (!rst_n)                    q[i*W +: W] <= '0;
            else if (we && idx == 2'(i))   q[i*W +: W] <= wdata;
        end
    end

    // Select the addressed controller for readback
    always_comb begin
        rd_q = '0;
        for (int i = 0; i < COUNT; i++)
            if (idx == 2'(i)) rd_q = q[i*W +: W];
    end

endmodule

// File: rtl/secwin_lane.sv
`timescale 1ns/1ps
// Extracts the byte lane(s) of a word for sub-word reads.
// Assumes size code 0 = byte, 1 = halfword, other = full word.
module secwin_lane (
    input  logic [31:0] word,
    input  logic [1:0]  off,
    input  logic [1:0]  size,
    output logic [31:0] lane
);

    logic [31:0] shifted;

    // Shift the addressed lane down and zero-extend it
    always_comb begin
        shifted = word >> {off, 3'b000};
        case (size)
            2'd0:    lane = {24'd0, shifted[7:0]};
            2'd1:    lane = {16'd0, shifted[15:0]};
            default: lane = word;
        endcase
    end

endmodule

// File: rtl/secwin_regbank.sv
`timescale 1ns/1ps
// Dual-window security configuration register bank (top).
// Secure window: global settings, bridge enable, non-secure and
// secure-privilege masks. Non-secure window: non-secure-privilege masks.
// Assumes MASK_W <= 32 and group counts <= 4.
module secwin_regbank
    import secwin_pkg::*;
#(
    parameter int MASK_W   = 16,
    parameter int NUM_AHBX = 4,
    parameter int NUM_APBI = 2,
    parameter int NUM_APBX = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       win_ns,
    input  logic [11:0]                addr,
    input  logic [31:0]                wdata,
    input  logic [1:0]                 size,
    input  logic                       wr_en,
    input  logic                       rd_en,
    output logic [31:0]                rdata,
    output logic                       resp_cfg,
    output logic [1:0]                 nsc_cfg,
    output logic [15:0]                brg_int_en,
    output logic [NUM_AHBX*MASK_W-1:0] ahbx_nonsec,
    output logic [NUM_APBI*MASK_W-1:0] apbi_nonsec,
    output logic [NUM_APBX*MASK_W-1:0] apbx_nonsec,
    output logic [NUM_AHBX*MASK_W-1:0] ahbx_secpriv,
    output logic [NUM_APBI*MASK_W-1:0] apbi_secpriv,
    output logic [NUM_APBX*MASK_W-1:0] apbx_secpriv,
    output logic [NUM_AHBX*MASK_W-1:0] ahbx_nspriv,
    output logic [NUM_APBI*MASK_W-1:0] apbi_nspriv,
    output logic [NUM_APBX*MASK_W-1:0] apbx_nspriv
);

    localparam int NKIND = 3;

    dec_t        dec;
    logic        wr_ok;
    logic        resp_q;
    logic [1:0]  call_q;
    logic [15:0] brg_q;
    logic [31:0] rd_word;
    logic [31:0] rd_lane;
    logic [31:0] rdata_q;

    logic [NUM_AHBX*MASK_W-1:0] ahbx_q  [NKIND];
    logic [NUM_APBI*MASK_W-1:0] apbi_q  [NKIND];
    logic [NUM_APBX*MASK_W-1:0] apbx_q  [NKIND];
    logic [MASK_W-1:0]          ahbx_rd [NKIND];
    logic [MASK_W-1:0]          apbi_rd [NKIND];
    logic [MASK_W-1:0]          apbx_rd [NKIND];

    secwin_decode #(
        .NUM_AHBX(NUM_AHBX), .NUM_APBI(NUM_APBI), .NUM_APBX(NUM_APBX)
    ) u_dec (
        .win_ns (win_ns),
        .waddr  (addr[11:2]),
        .dec    (dec)
    );

    assign wr_ok = wr_en && (size == 2'(SZ_WORD)) && (addr[1:0] == 2'b00);

    for (genvar k = 0; k < NKIND; k++) begin : g_kind
        logic we_k;
        assign we_k = wr_ok && dec.m.hit && (dec.m.kind == mask_kind_e'(k));

        secwin_mask_bank #(.COUNT(NUM_AHBX), .W(MASK_W)) u_ahbx (
            .clk(clk), .rst_n(rst_n), .we(we_k && dec.m.grp == GRP_AHBX),
            .idx(dec.m.idx), .wdata(wdata[MASK_W-1:0]),
            .q(ahbx_q[k]), .rd_q(ahbx_rd[k]));

        secwin_mask_bank #(.COUNT(NUM_APBI), .W(MASK_W)) u_apbi (
            .clk(clk), .rst_n(rst_n), .we(we_k && dec.m.grp == GRP_APBI),
            .idx(dec.m.idx), .wdata(wdata[MASK_W-1:0]),
            .q(apbi_q[k]), .rd_q(apbi_rd[k]));

        secwin_mask_bank #(.COUNT(NUM_APBX), .W(MASK_W)) u_apbx (
            .clk(clk), .rst_n(rst_n), .we(we_k && dec.m.grp == GRP_APBX),
            .idx(dec.m.idx), .wdata(wdata[MASK_W-1:0]),
            .q(apbx_q[k]), .rd_q(apbx_rd[k]));
    end

    // Global secure settings and bridge enable field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= 1'b0;
            call_q <= 2'd0;
            brg_q  <= 16'd0;
        end else if (wr_ok) begin
            if (dec.resp)  resp_q <= wdata[0];
            if (dec.call)  call_q <= wdata[1:0];
            if (dec.brgen) brg_q  <= wdata[31:16];
        end
    end

    // Assemble the full word for the addressed register
    always_comb begin
        rd_word = '0;
        if (dec.m.hit) begin
            for (int k = 0; k < NKIND; k++) begin
                if (dec.m.kind == mask_kind_e'(k)) begin
                    case (dec.m.grp)
                        GRP_AHBX: rd_word = 32'(ahbx_rd[k]);
                        GRP_APBI: rd_word = 32'(apbi_rd[k]);
                        GRP_APBX: rd_word = 32'(apbx_rd[k]);
                        default:  rd_word = '0;
                    endcase
                end
            end
        end else if (dec.resp) begin
            rd_word = {31'd0, resp_q};
        end else if (dec.call) begin
            rd_word = {30'd0, call_q};
        end else if (dec.brgen) begin
            rd_word = {brg_q, 16'd0};
        end else if (dec.id) begin
            rd_word = {24'd0, id_byte(dec.id_n, win_ns)};
        end
    end

    secwin_lane u_lane (
        .word (rd_word),
        .off  (addr[1:0]),
        .size (size),
        .lane (rd_lane)
    );

    // Register read data on each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_lane;
    end

    assign rdata        = rdata_q;
    assign resp_cfg     = resp_q;
    assign nsc_cfg      = call_q;
    assign brg_int_en   = brg_q;
    assign ahbx_nonsec  = ahbx_q[KIND_NS];
    assign apbi_nonsec  = apbi_q[KIND_NS];
    assign apbx_nonsec  = apbx_q[KIND_NS];
    assign ahbx_secpriv = ahbx_q[KIND_SP];
    assign apbi_secpriv = apbi_q[KIND_SP];
    assign apbx_secpriv = apbx_q[KIND_SP];
    assign ahbx_nspriv  = ahbx_q[KIND_NSP];
    assign apbi_nspriv  = apbi_q[KIND_NSP];
    assign apbx_nspriv  = apbx_q[KIND_NSP];

endmodule

// File: rtl/secwin_regbank_chk.sv
`timescale 1ns/1ps
// Property checker for secwin_regbank, attached by bind.
// Assumes inputs are known whenever a strobe is high.
module secwin_regbank_chk #(
    parameter int MASK_W   = 16,
    parameter int NUM_AHBX = 4,
    parameter int NUM_APBI = 2,
    parameter int NUM_APBX = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       win_ns,
    input logic [11:0]                addr,
    input logic [31:0]                wdata,
    input logic [1:0]                 size,
    input logic                       wr_en,
    input logic                       rd_en,
    input logic [31:0]                rdata,
    input logic                       resp_cfg,
    input logic [1:0]                 nsc_cfg,
    input logic [15:0]                brg_int_en,
    input logic [NUM_AHBX*MASK_W-1:0] ahbx_nonsec,
    input logic [NUM_APBI*MASK_W-1:0] apbi_nonsec,
    input logic [NUM_APBX*MASK_W-1:0] apbx_nonsec,
    input logic [NUM_AHBX*MASK_W-1:0] ahbx_secpriv,
    input logic [NUM_APBI*MASK_W-1:0] apbi_secpriv,
    input logic [NUM_APBX*MASK_W-1:0] apbx_secpriv,
    input logic [NUM_AHBX*MASK_W-1:0] ahbx_nspriv,
    input logic [NUM_APBI*MASK_W-1:0] apbi_nspriv,
    input logic [NUM_APBX*MASK_W-1:0] apbx_nspriv
);

    logic word_wr;
    assign word_wr = wr_en && size == 2'd2 && addr[1:0] == 2'b00;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (resp_cfg == 1'b0 && nsc_cfg == 2'd0 && brg_int_en == 16'd0 &&
                    ahbx_nonsec == '0 && apbi_nonsec == '0 && apbx_nonsec == '0 &&
                    ahbx_secpriv == '0 && apbi_secpriv == '0 && apbx_secpriv == '0 &&
                    ahbx_nspriv == '0 && apbi_nspriv == '0 && apbx_nspriv == '0 &&
                    rdata == 32'd0)); // R1

    AST_RESP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr && !win_ns && addr == 12'h010) |=> resp_cfg == $past(wdata[0])); // R2

    AST_BRG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr && !win_ns && addr == 12'h048) |=> brg_int_en == $past(wdata[31:16])); // R3

    AST_NS_WINDOW_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && win_ns) |=> ($stable(resp_cfg) && $stable(nsc_cfg) && $stable(brg_int_en) &&
                               $stable(ahbx_nonsec) && $stable(apbi_nonsec) && $stable(apbx_nonsec) &&
                               $stable(ahbx_secpriv) && $stable(apbi_secpriv) && $stable(apbx_secpriv))); // R6

    AST_PARTIAL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !word_wr) |=> ($stable(resp_cfg) && $stable(nsc_cfg) && $stable(brg_int_en) &&
                                 $stable(ahbx_nonsec) && $stable(apbi_nonsec) && $stable(apbx_nonsec) &&
                                 $stable(ahbx_secpriv) && $stable(apbi_secpriv) && $stable(apbx_secpriv) &&
                                 $stable(ahbx_nspriv) && $stable(apbi_nspriv) && $stable(apbx_nspriv))); // R9

    AST_READ_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R11

endmodule

bind secwin_regbank secwin_regbank_chk #(
    .MASK_W(MASK_W), .NUM_AHBX(NUM_AHBX), .NUM_APBI(NUM_APBI), .NUM_APBX(NUM_APBX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .win_ns(win_ns), .addr(addr), .wdata(wdata),
    .size(size), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .resp_cfg(resp_cfg), .nsc_cfg(nsc_cfg), .brg_int_en(brg_int_en),
    .ahbx_nonsec(ahbx_nonsec), .apbi_nonsec(apbi_nonsec), .apbx_nonsec(apbx_nonsec),
    .ahbx_secpriv(ahbx_secpriv), .apbi_secpriv(apbi_secpriv), .apbx_secpriv(apbx_secpriv),
    .ahbx_nspriv(ahbx_nspriv), .apbi_nspriv(apbi_nspriv), .apbx_nspriv(apbx_nspriv)
);

// File: tb/sim_secwin_regbank.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected data, a monitor compares it.
module sim_secwin_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_ns = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [1:0]  size = 2'd2;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        resp_cfg;
    logic [1:0]  nsc_cfg;
    logic [15:0] brg_int_en;
    logic [63:0] ahbx_nonsec, apbx_nonsec, ahbx_secpriv, apbx_secpriv, ahbx_nspriv, apbx_nspriv;
    logic [31:0] apbi_nonsec, apbi_secpriv, apbi_nspriv;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    logic [31:0] last_exp = '0;

    always #2.5 clk = ~clk;

    secwin_regbank u0 (
        .clk(clk), .rst_n(rst_n), .win_ns(win_ns), .addr(addr), .wdata(wdata),
        .size(size), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .resp_cfg(resp_cfg), .nsc_cfg(nsc_cfg), .brg_int_en(brg_int_en),
        .ahbx_nonsec(ahbx_nonsec), .apbi_nonsec(apbi_nonsec), .apbx_nonsec(apbx_nonsec),
        .ahbx_secpriv(ahbx_secpriv), .apbi_secpriv(apbi_secpriv), .apbx_secpriv(apbx_secpriv),
        .ahbx_nspriv(ahbx_nspriv), .apbi_nspriv(apbi_nspriv), .apbx_nspriv(apbx_nspriv)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic ns, input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        win_ns = ns; addr = a; wdata = d; size = sz; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic ns, input logic [11:0] a, input logic [1:0] sz,
                      input logic [31:0] exp, input string tag);
        @(negedge clk);
        win_ns = ns; addr = a; size = sz; rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        last_exp = exp;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Note which edges captured a read
    always @(posedge clk) rd_seen <= rd_en && rst_n;

    // Monitor: compare registered read data with the queued expectation
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", t, rdata, e);
            end
        end
    end

    task automatic check_all_zero(input string tag);
        chk({63'd0, resp_cfg}, 64'd0, tag);
        chk({62'd0, nsc_cfg}, 64'd0, tag);
        chk({48'd0, brg_int_en}, 64'd0, tag);
        chk(ahbx_nonsec | apbx_nonsec | ahbx_secpriv | apbx_secpriv | ahbx_nspriv | apbx_nspriv,
            64'd0, tag);
        chk({32'd0, apbi_nonsec | apbi_secpriv | apbi_nspriv}, 64'd0, tag);
        chk({32'd0, rdata}, 64'd0, tag);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all_zero("R1 reset state");
        rst_n = 1'b1;
        rd(1'b0, 12'h010, 2'd2, 32'd0, "R1 resp after reset");

        // R2 global settings
        wr(1'b0, 12'h010, 32'hFFFF_FFFF, 2'd2);
        chk({63'd0, resp_cfg}, 64'd1, "R2 resp_cfg output");
        rd(1'b0, 12'h010, 2'd2, 32'd1, "R2 resp readback");
        wr(1'b0, 12'h014, 32'hFFFF_FFFE, 2'd2);
        chk({62'd0, nsc_cfg}, 64'd2, "R2 nsc_cfg output");
        rd(1'b0, 12'h014, 2'd2, 32'd2, "R2 callable readback");

        // R3 bridge enable
        wr(1'b0, 12'h048, 32'h1234_ABCD, 2'd2);
        chk({48'd0, brg_int_en}, 64'h1234, "R3 brg output");
        rd(1'b0, 12'h048, 2'd2, 32'h1234_0000, "R3 brg readback");
        rd(1'b0, 12'h040, 2'd2, 32'd0, "R3 bridge status zero");

        // R4 non-secure masks
        wr(1'b0, 12'h064, 32'hFFFF_BEEF, 2'd2);
        chk(ahbx_nonsec, 64'h0000_0000_BEEF_0000, "R4 ahbx ns idx1");
        rd(1'b0, 12'h064, 2'd2, 32'h0000_BEEF, "R4 ahbx ns readback");
        wr(1'b0, 12'h074, 32'h0000_5A5A, 2'd2);
        chk({32'd0, apbi_nonsec}, 64'h5A5A_0000, "R4 apbi ns idx1");
        wr(1'b0, 12'h08C, 32'h0000_1111, 2'd2);
        chk(apbx_nonsec, 64'h1111_0000_0000_0000, "R4 apbx ns idx3");

        // R5 secure-privilege masks
        wr(1'b0, 12'h0A0, 32'h0000_0F0F, 2'd2);
        chk(ahbx_secpriv, 64'h0F0F, "R5 ahbx sp idx0");
        wr(1'b0, 12'h0B0, 32'h0000_2222, 2'd2);
        chk({32'd0, apbi_secpriv}, 64'h2222, "R5 apbi sp idx0");
        wr(1'b0, 12'h0C8, 32'h0000_3333, 2'd2);
        chk(apbx_secpriv, 64'h0000_3333_0000_0000, "R5 apbx sp idx2");
        rd(1'b0, 12'h0C8, 2'd2, 32'h3333, "R5 apbx sp readback");

        // R6 non-secure window
        wr(1'b1, 12'h0A0, 32'h0000_7777, 2'd2);
        chk(ahbx_nspriv, 64'h7777, "R6 ahbx nsp idx0");
        chk(ahbx_secpriv, 64'h0F0F, "R6 sp untouched by ns window");
        rd(1'b1, 12'h0A0, 2'd2, 32'h7777, "R6 nsp readback");
        rd(1'b0, 12'h0A0, 2'd2, 32'h0F0F, "R6 secure sees sp");
        wr(1'b1, 12'h010, 32'd0, 2'd2);
        chk({63'd0, resp_cfg}, 64'd1, "R6 ns write to 0x10 ignored");
        wr(1'b1, 12'h064, 32'd0, 2'd2);
        chk(ahbx_nonsec, 64'h0000_0000_BEEF_0000, "R6 ns write to 0x64 ignored");
        rd(1'b1, 12'h010, 2'd2, 32'd0, "R6 ns read of 0x10");
        rd(1'b1, 12'h064, 2'd2, 32'd0, "R6 ns read of 0x64");
        wr(1'b1, 12'h0C4, 32'h0000_4444, 2'd2);
        chk(apbx_nspriv, 64'h0000_0000_4444_0000, "R6 apbx nsp idx1");

        // R7 identification bytes
        rd(1'b0, 12'hFE0, 2'd2, 32'h52, "R7 secure byte4");
        rd(1'b1, 12'hFE0, 2'd2, 32'h53, "R7 ns byte4");
        rd(1'b0, 12'hFFC, 2'd2, 32'hB1, "R7 last byte");
        rd(1'b1, 12'hFD0, 2'd2, 32'h04, "R7 first byte");
        rd(1'b0, 12'hFF4, 2'd2, 32'hF0, "R7 byte9");

        // R8 sub-word reads
        rd(1'b0, 12'h04A, 2'd1, 32'h1234, "R8 half upper");
        rd(1'b0, 12'h04B, 2'd0, 32'h12, "R8 byte lane3");
        rd(1'b0, 12'h064, 2'd0, 32'hEF, "R8 byte lane0");
        rd(1'b0, 12'h065, 2'd0, 32'hBE, "R8 byte lane1");

        // R9 dropped writes
        wr(1'b0, 12'h010, 32'd0, 2'd1);
        chk({63'd0, resp_cfg}, 64'd1, "R9 half write dropped");
        wr(1'b0, 12'h064, 32'd0, 2'd0);
        chk(ahbx_nonsec, 64'h0000_0000_BEEF_0000, "R9 byte write dropped");
        wr(1'b0, 12'h066, 32'd0, 2'd2);
        chk(ahbx_nonsec, 64'h0000_0000_BEEF_0000, "R9 unaligned write dropped");

        // R10 read-only, write-only and undecoded offsets
        wr(1'b0, 12'h050, 32'hFFFF_FFFF, 2'd2);
        rd(1'b0, 12'h050, 2'd2, 32'd0, "R10 0x50 reads zero");
        rd(1'b0, 12'h090, 2'd2, 32'd0, "R10 0x90 reads zero");
        rd(1'b1, 12'h090, 2'd2, 32'd0, "R10 ns 0x90 reads zero");
        wr(1'b0, 12'h024, 32'hFFFF_FFFF, 2'd2);
        rd(1'b0, 12'h024, 2'd2, 32'd0, "R10 clear reads zero");
        wr(1'b0, 12'h078, 32'hFFFF_FFFF, 2'd2);
        rd(1'b0, 12'h078, 2'd2, 32'd0, "R10 apbi idx2 undecoded");
        chk({32'd0, apbi_nonsec}, 64'h5A5A_0000, "R10 apbi untouched");
        wr(1'b0, 12'hFE0, 32'hFF, 2'd2);
        rd(1'b0, 12'hFE0, 2'd2, 32'h52, "R10 id write ignored");
        wr(1'b0, 12'h300, 32'hFFFF_FFFF, 2'd2);
        rd(1'b0, 12'h300, 2'd2, 32'd0, "R10 undecoded reads zero");

        // R11 read data holds
        repeat (4) @(negedge clk);
        chk({32'd0, rdata}, {32'd0, last_exp}, "R11 rdata holds");

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_all_zero("R1 reset mid-run");
        rst_n = 1'b1;

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule